// File: doc/BRIEF.md
# Word-Fed Transmit Frame Assembler

This block collects an outgoing Ethernet frame from 32-bit words that a host writes one at a time, then releases it as a byte stream. The first word accepted while the block is idle is a header. Its low half holds the payload length, which excludes the 14-byte Ethernet header. Its upper half holds the first two frame bytes. Every later word adds four bytes. From the header the block works out how many bytes it must collect. When that count is reached it can strip the trailing check-sum bytes that the host supplied, zero-pad a short frame, and stream the result.

Two sticky interrupt flags report the outcome. One flags an oversized length. The other flags that a frame has finished streaming. Acknowledging the error flag also throws away any frame that is only partly collected. While a frame is streaming, the write port deasserts its ready signal, so a word the host offers in that time waits instead of being lost.

Top module: `tx_frame_asm`

## Requirements
- R1: After reset the block is idle, `wr_ready` is 1, `tx_valid` is 0 and both interrupt flags are 0.
- R2: A header whose bits 15:0 exceed 2032 sets `irq_tx_err`, emits nothing, and leaves the block idle with `wr_ready` at 1.
- R3: For an accepted header of length L, the target byte count is L+14, plus 4 more when `crc_en` is 0. The frame starts streaming only after the data word that brings the count (2 header bytes plus 4 per word) to the target or past it.
- R4: Frame bytes 0 and 1 are header bits 23:16 and 31:24. Each data word then supplies four bytes in the order bits 7:0, 15:8, 23:16, 31:24.
- R5: When `crc_en` is 0 at header time, the final 4 collected bytes are dropped, and the frame carries L+14 bytes.
- R6: When `pad_en` is 1 as the frame completes and L+14 is below 60, the frame is 60 bytes long. Every byte from position L+14 onward is zero.
- R7: When `pad_en` is 0, the frame length is L+14 even when that is below 60.
- R8: A frame is streamed with `tx_valid` high on consecutive cycles. `tx_sof` marks only the first byte and `tx_eof` only the last.
- R9: `irq_tx_empty` is set in the same cycle as the last byte and is cleared by `empty_ack`.
- R10: `err_ack` during collection discards the partial frame, and the next write is taken as a header.
- R11: `wr_ready` is 0 while a frame streams. A word held on `wr_valid` during that time is taken once the block is idle again.
- R12: `err_ack` clears `irq_tx_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Host offers a data word |
| wr_data | input | 32 | Data word (header or body) |
| wr_ready | output | 1 | Word is taken on a cycle where valid and ready are both 1 |
| crc_en | input | 1 | 1: host omits check-sum bytes; 0: host supplies 4 that are stripped |
| pad_en | input | 1 | Pad short frames to 60 bytes |
| err_ack | input | 1 | Acknowledge the length error and abort collection |
| empty_ack | input | 1 | Acknowledge the transmit-done flag |
| tx_valid | output | 1 | Stream byte valid |
| tx_data | output | 8 | Stream byte |
| tx_sof | output | 1 | First byte of a frame |
| tx_eof | output | 1 | Last byte of a frame |
| irq_tx_err | output | 1 | Oversize-length flag |
| irq_tx_empty | output | 1 | Frame-sent flag |

## Verification
The bound checker watches the stream framing on every cycle: start and end markers only with valid data, no gaps inside a frame, and a single start marker. It also checks that `wr_ready` is low while a frame streams and how each acknowledge acts on its flag. Only the bench scenarios can show the length arithmetic, the byte order, stripping and zero padding, the oversize rejection, and that a held word or an abort leaves the next frame intact. Each of these is compared against a byte model built from the requirements.

// File: rtl/tx_asm_pkg.sv
`timescale 1ns/1ps
package tx_asm_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_FILL = 2'd1,
      ST_SEND = 2'd2
   } asm_state_e;
endpackage

// File: rtl/tx_len_calc.sv
`timescale 1ns/1ps
module tx_len_calc #(
   parameter int LEN_W       = 16,
   parameter int CNT_W       = 13,
   parameter int MAX_PAYLOAD = 2032,
   parameter int HDR_BYTES   = 14,
   parameter int CRC_BYTES   = 4
)(
   input  logic [LEN_W-1:0] payload_len,
   input  logic             crc_en,
   output logic             oversize,
   output logic [CNT_W-1:0] keep_len,
   output logic [CNT_W-1:0] target_len
);
   // bytes kept on the wire versus bytes the host will deliver
   always_comb begin
      oversize   = payload_len > LEN_W'(MAX_PAYLOAD);
      keep_len   = CNT_W'(payload_len) + CNT_W'(HDR_BYTES);
      target_len = keep_len + (crc_en ? CNT_W'(0) : CNT_W'(CRC_BYTES));
   end
endmodule

// File: rtl/tx_pad_sel.sv
`timescale 1ns/1ps
module tx_pad_sel #(
   parameter int CNT_W     = 13,
   parameter int MIN_FRAME = 60
)(
   input  logic             pad_en,
   input  logic [CNT_W-1:0] keep_len,
   output logic [CNT_W-1:0] send_len
);
   if (MIN_FRAME > 0) begin : g_pad
      assign send_len = (pad_en && (keep_len < CNT_W'(MIN_FRAME)))
                        ? CNT_W'(MIN_FRAME) : keep_len;
   end else begin : g_nopad
      logic unused_pad;
      assign unused_pad = pad_en;
      assign send_len   = keep_len;
   end
endmodule

// File: rtl/tx_byte_bank.sv
`timescale 1ns/1ps
module tx_byte_bank #(
   parameter int ROW_W = 9
)(
   input  logic             clk,
   input  logic             we,
   input  logic [ROW_W-1:0] waddr,
   input  logic [7:0]       wdata,
   input  logic [ROW_W-1:0] raddr,
   output logic [7:0]       rdata
);
   logic [7:0] mem [2**ROW_W];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   assign rdata = mem[raddr];
endmodule

// File: rtl/tx_frame_asm.sv
`timescale 1ns/1ps
module tx_frame_asm
   import tx_asm_pkg::*;
#(
   parameter int DATA_W      = 32,
   parameter int DEPTH       = 2048,
   parameter int MAX_PAYLOAD = 2032,
   parameter int HDR_BYTES   = 14,
   parameter int CRC_BYTES   = 4,
   parameter int MIN_FRAME   = 60
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_valid,
   input  logic [DATA_W-1:0] wr_data,
   output logic              wr_ready,
   input  logic              crc_en,
   input  logic              pad_en,
   input  logic              err_ack,
   input  logic              empty_ack,
   output logic              tx_valid,
   output logic [7:0]        tx_data,
   output logic              tx_sof,
   output logic              tx_eof,
   output logic              irq_tx_err,
   output logic              irq_tx_empty
);
   localparam int LANES  = DATA_W / 8;
   localparam int LANE_W = $clog2(LANES);
   localparam int HALF   = LANES / 2;
   localparam int LEN_W  = DATA_W / 2;
   localparam int ADDR_W = $clog2(DEPTH);
   localparam int ROW_W  = ADDR_W - LANE_W;
   localparam int CNT_W  = $clog2(MAX_PAYLOAD + HDR_BYTES + CRC_BYTES + 2*LANES) + 1;

   // elaboration-time parameter checks
   if (DATA_W < 32 || (DATA_W % 16) != 0) begin : g_bad_width
      $error("tx_frame_asm: DATA_W must be a multiple of 16, at least 32");
   end
   if ((LANES & (LANES - 1)) != 0) begin : g_bad_lanes
      $error("tx_frame_asm: byte lanes must be a power of two");
   end
   if (DEPTH != (1 << ADDR_W)) begin : g_bad_depth
      $error("tx_frame_asm: DEPTH must be a power of two");
   end
   if (MAX_PAYLOAD + HDR_BYTES > DEPTH) begin : g_bad_max
      $error("tx_frame_asm: largest kept frame exceeds buffer");
   end
   if (MAX_PAYLOAD >= (1 << LEN_W)) begin : g_bad_len
      $error("tx_frame_asm: length field too narrow for MAX_PAYLOAD");
   end
   if (MIN_FRAME > DEPTH) begin : g_bad_min
      $error("tx_frame_asm: MIN_FRAME exceeds buffer");
   end

   asm_state_e       state;
   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] target_q;
   logic [CNT_W-1:0] keep_q;
   logic [CNT_W-1:0] send_q;
   logic [CNT_W-1:0] idx;

   logic             hdr_fire;
   logic             data_fire;
   logic             fill_done;
   logic             last_byte;
   logic [CNT_W-1:0] cnt_next;
   logic             hdr_big;
   logic [CNT_W-1:0] hdr_keep;
   logic [CNT_W-1:0] hdr_target;
   logic [CNT_W-1:0] pad_len;

   logic [ROW_W-1:0]  rd_row;
   logic [LANE_W-1:0] rd_lane;
   logic [7:0]        rd_bytes [LANES];
   logic [7:0]        rd_byte;

   assign wr_ready  = (state != ST_SEND);
   assign hdr_fire  = wr_valid && (state == ST_IDLE);
   assign data_fire = wr_valid && (state == ST_FILL) && !err_ack;
   assign cnt_next  = cnt + CNT_W'(LANES);
   assign fill_done = data_fire && (cnt_next >= target_q);
   assign last_byte = (idx == send_q - CNT_W'(1));

   tx_len_calc #(
      .LEN_W       (LEN_W),
      .CNT_W       (CNT_W),
      .MAX_PAYLOAD (MAX_PAYLOAD),
      .HDR_BYTES   (HDR_BYTES),
      .CRC_BYTES   (CRC_BYTES)
   ) u_len (
      .payload_len (wr_data[LEN_W-1:0]),
      .crc_en      (crc_en),
      .oversize    (hdr_big),
      .keep_len    (hdr_keep),
      .target_len  (hdr_target)
   );

   tx_pad_sel #(
      .CNT_W     (CNT_W),
      .MIN_FRAME (MIN_FRAME)
   ) u_pad (
      .pad_en   (pad_en),
      .keep_len (keep_q),
      .send_len (pad_len)
   );

   assign rd_row  = idx[ADDR_W-1:LANE_W];
   assign rd_lane = idx[LANE_W-1:0];
   assign rd_byte = rd_bytes[rd_lane];

   // one byte-wide bank per lane; a word lands across two rows when the
   // running count is not lane aligned
   for (genvar L = 0; L < LANES; L++) begin : g_lane
      logic [LANE_W-1:0] slot;
      logic [CNT_W-1:0]  baddr;
      logic              we;
      logic [ROW_W-1:0]  waddr;
      logic [7:0]        wdata;
      logic [7:0]        hbyte;
      logic              body_ok;

      assign slot    = LANE_W'(L) - cnt[LANE_W-1:0];
      assign baddr   = cnt + CNT_W'(slot);
      assign body_ok = data_fire && (baddr < CNT_W'(DEPTH));

      if (L < HALF) begin : g_hdr
         assign hbyte = wr_data[(HALF+L)*8 +: 8];
         assign we    = (hdr_fire && !hdr_big) || body_ok;
      end else begin : g_body
         assign hbyte = 8'h00;
         assign we    = body_ok;
      end

      assign waddr = hdr_fire ? '0 : baddr[ADDR_W-1:LANE_W];
      assign wdata = hdr_fire ? hbyte : wr_data[slot*8 +: 8];

      tx_byte_bank #(.ROW_W(ROW_W)) u_bank (
         .clk   (clk),
         .we    (we),
         .waddr (waddr),
         .wdata (wdata),
         .raddr (rd_row),
         .rdata (rd_bytes[L])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state        <= ST_IDLE;
         cnt          <= '0;
         target_q     <= '0;
         keep_q       <= '0;
         send_q       <= '0;
         idx          <= '0;
         tx_valid     <= 1'b0;
         tx_data      <= 8'h00;
         tx_sof       <= 1'b0;
         tx_eof       <= 1'b0;
         irq_tx_err   <= 1'b0;
         irq_tx_empty <= 1'b0;
      end else begin
         tx_valid <= 1'b0;
         tx_data  <= 8'h00;
         tx_sof   <= 1'b0;
         tx_eof   <= 1'b0;

         case (state)
            ST_IDLE: begin
               if (hdr_fire && !hdr_big) begin
                  state    <= ST_FILL;
                  cnt      <= CNT_W'(HALF);
                  target_q <= hdr_target;
                  keep_q   <= hdr_keep;
               end
            end
            ST_FILL: begin
               if (err_ack) begin
                  state <= ST_IDLE;
                  cnt   <= '0;
               end else if (data_fire) begin
                  cnt <= cnt_next;
                  if (fill_done) begin
                     state  <= ST_SEND;
                     send_q <= pad_len;
                     idx    <= '0;
                  end
               end
            end
            ST_SEND: begin
               tx_valid <= 1'b1;
               tx_data  <= (idx < keep_q) ? rd_byte : 8'h00;
               tx_sof   <= (idx == '0);
               tx_eof   <= last_byte;
               idx      <= idx + CNT_W'(1);
               if (last_byte) begin
                  state <= ST_IDLE;
                  cnt   <= '0;
               end
            end
            default: state <= ST_IDLE;
         endcase

         if ((state == ST_SEND) && last_byte) irq_tx_empty <= 1'b1;
         else if (empty_ack)                  irq_tx_empty <= 1'b0;

         if (hdr_fire && hdr_big) irq_tx_err <= 1'b1;
         else if (err_ack)        irq_tx_err <= 1'b0;
      end
   end
endmodule

// File: rtl/tx_frame_asm_chk.sv
`timescale 1ns/1ps
module tx_frame_asm_chk (
   input logic clk,
   input logic rst_n,
   input logic wr_valid,
   input logic wr_ready,
   input logic err_ack,
   input logic empty_ack,
   input logic tx_valid,
   input logic tx_sof,
   input logic tx_eof,
   input logic irq_tx_err,
   input logic irq_tx_empty
);
   // R8
   mark_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_sof || tx_eof) |-> tx_valid);

   // R8
   no_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && !tx_eof) |=> tx_valid);

   // R8
   single_sof_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_sof |=> !tx_sof);

   // R11
   busy_stream_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && !tx_eof) |-> !wr_ready);

   // R9
   empty_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_eof |-> irq_tx_empty);

   // R9
   empty_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      empty_ack |=> (!irq_tx_empty || tx_eof));

   // R12
   err_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (err_ack && !wr_valid) |=> !irq_tx_err);
endmodule

bind tx_frame_asm tx_frame_asm_chk u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .wr_valid     (wr_valid),
   .wr_ready     (wr_ready),
   .err_ack      (err_ack),
   .empty_ack    (empty_ack),
   .tx_valid     (tx_valid),
   .tx_sof       (tx_sof),
   .tx_eof       (tx_eof),
   .irq_tx_err   (irq_tx_err),
   .irq_tx_empty (irq_tx_empty)
);

// File: tb/tx_frame_asm_bench.sv
`timescale 1ns/1ps
module tx_frame_asm_bench;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        wr_valid;
   logic [31:0] wr_data;
   logic        wr_ready;
   logic        crc_en;
   logic        pad_en;
   logic        err_ack;
   logic        empty_ack;
   logic        tx_valid;
   logic [7:0]  tx_data;
   logic        tx_sof;
   logic        tx_eof;
   logic        irq_tx_err;
   logic        irq_tx_empty;

   always #2.5 clk = ~clk;

   tx_frame_asm u_tx_frame_asm (
      .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
      .wr_ready(wr_ready), .crc_en(crc_en), .pad_en(pad_en),
      .err_ack(err_ack), .empty_ack(empty_ack), .tx_valid(tx_valid),
      .tx_data(tx_data), .tx_sof(tx_sof), .tx_eof(tx_eof),
      .irq_tx_err(irq_tx_err), .irq_tx_empty(irq_tx_empty)
   );

   int n_chk = 0;
   int n_bad = 0;
   bit done_rep = 0;

   // {payload length[15:0], crc_en, pad_en}
   localparam logic [17:0] VEC [9] = '{
      {16'd46,   1'b1, 1'b0},
      {16'd46,   1'b0, 1'b0},
      {16'd10,   1'b1, 1'b1},
      {16'd10,   1'b1, 1'b0},
      {16'd0,    1'b0, 1'b1},
      {16'd3,    1'b0, 1'b0},
      {16'd100,  1'b1, 1'b1},
      {16'd2032, 1'b1, 1'b0},
      {16'd2032, 1'b0, 1'b1}
   };

   logic [7:0] cap   [0:2047];
   logic [7:0] exp_b [0:2063];
   int cap_len = 0;
   int frames = 0;
   int frame_err = 0;
   bit in_frame = 0;

   always @(negedge clk) begin
      if (rst_n) begin
         if (tx_valid) begin
            if (tx_sof) begin
               if (in_frame) frame_err++;
               cap_len = 0;
               in_frame = 1;
            end else if (!in_frame) frame_err++;
            if (cap_len < 2048) cap[cap_len] = tx_data;
            cap_len++;
            if (tx_eof) begin
               in_frame = 0;
               frames++;
            end
         end else if (in_frame || tx_sof || tx_eof) frame_err++;
      end
   end

   task automatic report();
      if (!done_rep) begin
         done_rep = 1;
         $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      end
   endtask

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic logic [31:0] mkword(input int s, input int k);
      return (32'h9E3779B9 * (k + 1)) ^ {s[15:0], ~s[15:0]};
   endfunction

   task automatic put(input logic [31:0] d);
      @(negedge clk);
      wr_valid = 1'b1;
      wr_data  = d;
      while (!wr_ready) @(negedge clk);
      @(negedge clk);
      wr_valid = 1'b0;
   endtask

   task automatic pulse_err();
      @(negedge clk); err_ack = 1'b1;
      @(negedge clk); err_ack = 1'b0;
   endtask

   task automatic pulse_empty();
      @(negedge clk); empty_ack = 1'b1;
      @(negedge clk); empty_ack = 1'b0;
   endtask

   task automatic wait_frame(input int f0);
      for (int t = 0; t < 5000 && frames == f0; t++) @(negedge clk);
   endtask

   // collect and check one frame; no_wait leaves it streaming unchecked
   task automatic run_frame(input int len, input bit crc, input bit pad,
                            input int seed, input bit early, input bit no_wait);
      int keep, target, slen, nw, f0, mism, e;
      logic [31:0] hdr, w;
      keep   = len + 14;
      target = keep + (crc ? 0 : 4);
      slen   = (pad && keep < 60) ? 60 : keep;
      nw     = (target - 2 + 3) / 4;
      @(negedge clk);
      crc_en = crc;
      pad_en = pad;
      hdr = {seed[15:0], len[15:0]};
      exp_b[0] = hdr[23:16];
      exp_b[1] = hdr[31:24];
      put(hdr);
      f0 = frames;
      for (int k = 0; k < nw; k++) begin
         w = mkword(seed, k);
         for (int i = 0; i < 4; i++) exp_b[2 + 4*k + i] = w[8*i +: 8];
         if (early && k == nw - 1) begin
            repeat (3) @(negedge clk);
            // R3: nothing released before the final word
            chk(frames == f0 && !tx_valid && wr_ready, "R3 early release", frames - f0, 0);
         end
         put(w);
      end
      // R11: streaming blocks new words
      chk(!wr_ready, "R11 ready during stream", wr_ready, 0);
      if (!no_wait) begin
         wait_frame(f0);
         chk(frames == f0 + 1, "R3 frame emitted", frames - f0, 1);
         // R5 R6 R7: length
         chk(cap_len == slen, crc ? (pad ? "R6 length" : "R7 length") : "R5 length", cap_len, slen);
         mism = 0;
         for (int i = 0; i < slen && i < 2048; i++) begin
            e = (i < keep) ? int'(exp_b[i]) : 0;
            if (int'(cap[i]) != e) mism++;
         end
         // R4 R6: byte order and zero fill
         chk(mism == 0, "R4/R6 byte content", mism, 0);
         chk(frame_err == 0, "R8 stream framing", frame_err, 0);
         chk(irq_tx_empty, "R9 empty flag set", irq_tx_empty, 1);
         pulse_empty();
         chk(!irq_tx_empty, "R9 empty flag cleared", irq_tx_empty, 0);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired actual=0 expected=1");
      report();
      $finish;
   end

   initial begin
      int f0;
      rst_n = 1'b0; wr_valid = 1'b0; wr_data = '0; crc_en = 1'b1;
      pad_en = 1'b0; err_ack = 1'b0; empty_ack = 1'b0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1
      chk(wr_ready, "R1 reset ready", wr_ready, 1);
      chk(!tx_valid, "R1 reset valid", tx_valid, 0);
      chk(!irq_tx_err, "R1 reset err flag", irq_tx_err, 0);
      chk(!irq_tx_empty, "R1 reset empty flag", irq_tx_empty, 0);

      for (int v = 0; v < 9; v++)
         run_frame(int'(VEC[v][17:2]), VEC[v][1], VEC[v][0], v*77 + 5, 1'b1, 1'b0);

      // R2: oversize rejected
      f0 = frames;
      put({16'hABCD, 16'd2033});
      repeat (3) @(negedge clk);
      chk(irq_tx_err, "R2 oversize flag", irq_tx_err, 1);
      chk(frames == f0 && wr_ready && !tx_valid, "R2 stays idle", frames - f0, 0);
      // R12
      pulse_err();
      chk(!irq_tx_err, "R12 err flag cleared", irq_tx_err, 0);
      // R2: still idle, so a normal frame follows cleanly
      run_frame(20, 1'b1, 1'b0, 901, 1'b0, 1'b0);

      // R10: abort a partial frame
      put({16'h1234, 16'd40});
      put(32'hDEADBEEF);
      put(32'hCAFEF00D);
      pulse_err();
      f0 = frames;
      run_frame(20, 1'b1, 1'b0, 333, 1'b0, 1'b0);
      chk(frames == f0 + 1 && cap_len == 34, "R10 abort then clean frame", cap_len, 34);

      // R11: header offered while the previous frame streams
      run_frame(50, 1'b1, 1'b0, 444, 1'b0, 1'b1);
      f0 = frames;
      run_frame(12, 1'b0, 1'b1, 555, 1'b0, 1'b0);
      chk(frames == f0 + 2, "R11 held word taken", frames - f0, 2);

      repeat (5) @(negedge clk);
      report();
      $finish;
   end
endmodule